// File: doc/BRIEF.md
# Prescaled PWM Channel with Register Control

A single pulse width modulator channel set up through a small register file on a simple memory-mapped bus. The bus has byte-lane enables, so software may write a whole 16-bit register or only one of its bytes. A prescaler divides the input clock into ticks. A period register sets the cycle length in ticks, and a duty register sets the active time in ticks. Each of these registers holds its value minus one.

A control byte holds the run bit, the output polarity, the tick source select and a mode field. The tick source is either every clock or a strobe from a slower clock domain. An extension byte holds a source-select field and a drive-style flag. The block stores the mode field and the extension byte and reads them back, but they have no effect on the waveform here.

While the channel runs, the block captures new timing values into shadow copies only at a period boundary. Reprogramming a running channel therefore never cuts a pulse short or stretches it. Software clears the run bit to stop the channel. This parks the output at its inactive level and clears every counter, so the next start begins a fresh period.

Top module: `pwm_chan`

## Requirements
- R1: After reset every register reads zero and `pwm_o` is low.
- R2: Registers sit at byte offsets 0x0 (prescale), 0x2 (period), 0x4 (control, low byte) and 0x6 (duty). The extension byte is at 0xC, low byte. `be_i[0]` writes bits 7:0 and `be_i[1]` writes bits 15:8, each independently, and a read returns the addressed register on `rdata_o`.
- R3: Control keeps only bits 7, 3:2, 1 and 0 (mask 0x8F), and the extension keeps only bits 7 and 5:4 (mask 0xB0). The upper bytes at 0x4 and 0xC, offsets 0x8, 0xA and 0xE, and every other bit read zero. Writes there change nothing.
- R4: While control bit 7 is clear, the prescaler and period counters hold at zero and `pwm_o` equals control bit 0. When bit 7 is set, a new period begins with the output active.
- R5: With the run bit set, the output period is (period+1)·(prescale+1) ticks of the tick source, with one active interval per period.
- R6: With normal polarity, the output is high from the start of each period for (duty+1)·(prescale+1) clocks, then low until the period ends.
- R7: When duty ≥ period, the output stays active for the whole period, with no edges.
- R8: When control bit 0 is set, the waveform is inverted: the active interval is low and the idle level is high.
- R9: When control bit 1 is set, the prescaler advances only in cycles where `slow_en_i` is high. Otherwise it advances every clock.
- R10: Prescale, period and duty values written while the channel runs take effect at the next period boundary. The period in progress finishes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte address of the register |
| wr_i | input | 1 | Write strobe |
| be_i | input | 2 | Byte-lane enables for the write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| slow_en_i | input | 1 | One-cycle strobe from the slow clock domain |
| pwm_o | output | 1 | Modulated output |

## Verification
The bench sweeps small values of prescale, period and duty with both polarities. Over a window of exactly two periods, it counts active clocks and rising edges. A design that applied the minus-one encoding wrongly would be one tick off in width or period. A wrong comparison at duty = period would give a one-tick low glitch instead of a flat level. A single-byte write that disturbed the other lane, or a reserved bit that stuck, shows up as a wrong readback. The bench also rewrites the duty value just after a rising edge. A design without the shadow copies would shorten or stretch that pulse instead of changing the next one. Finally, the bench stops and restarts the channel. A design that kept its counters through the stop would begin partway into a period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // word index of each register (byte offset / 2)
  localparam int IDX_PRESC  = 0;
  localparam int IDX_PERIOD = 1;
  localparam int IDX_CTRL   = 2;
  localparam int IDX_DUTY   = 3;
  localparam int IDX_EXT    = 6;

  localparam logic [7:0] CTRL_MASK = 8'h8F;
  localparam logic [7:0] EXT_MASK  = 8'hB0;

  localparam int CTRL_INV  = 0;
  localparam int CTRL_SLOW = 1;
  localparam int CTRL_RUN  = 7;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [CNT_W/8-1:0]   be_i,
  input  logic [CNT_W-1:0]     wdata_i,
  output logic [CNT_W-1:0]     rdata_o,
  output logic [CNT_W-1:0]     presc_o,
  output logic [CNT_W-1:0]     period_o,
  output logic [CNT_W-1:0]     duty_o,
  output logic                 run_o,
  output logic                 inv_o,
  output logic                 slow_o
);
  localparam int NB = CNT_W / 8;
  localparam int LW = $clog2(NB);
  localparam int IW = ADDR_W - LW;

  logic [IW-1:0]    widx;
  logic [CNT_W-1:0] presc_q, period_q, duty_q;
  logic [7:0]       ctrl_q, ext_q;

  assign widx = addr_i[ADDR_W-1:LW];

  function automatic logic [CNT_W-1:0] lane_merge(input logic [CNT_W-1:0] old_v,
                                                  input logic [CNT_W-1:0] new_v,
                                                  input logic [NB-1:0]    be);
    logic [CNT_W-1:0] r;
    r = old_v;
    for (int b = 0; b < NB; b++)
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q  <= '0;
      period_q <= '0;
      duty_q   <= '0;
      ctrl_q   <= '0;
      ext_q    <= '0;
    end else if (wr_i) begin
      if (widx == IW'(IDX_PRESC))  presc_q  <= lane_merge(presc_q, wdata_i, be_i);
      if (widx == IW'(IDX_PERIOD)) period_q <= lane_merge(period_q, wdata_i, be_i);
      if (widx == IW'(IDX_DUTY))   duty_q   <= lane_merge(duty_q, wdata_i, be_i);
      if (widx == IW'(IDX_CTRL) && be_i[0]) ctrl_q <= wdata_i[7:0] & CTRL_MASK;
      if (widx == IW'(IDX_EXT)  && be_i[0]) ext_q  <= wdata_i[7:0] & EXT_MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (widx)
      IW'(IDX_PRESC):  rdata_o = presc_q;
      IW'(IDX_PERIOD): rdata_o = period_q;
      IW'(IDX_DUTY):   rdata_o = duty_q;
      IW'(IDX_CTRL):   rdata_o = CNT_W'(ctrl_q);
      IW'(IDX_EXT):    rdata_o = CNT_W'(ext_q);
      default:         rdata_o = '0;
    endcase
  end

  assign presc_o  = presc_q;
  assign period_o = period_q;
  assign duty_o   = duty_q;
  assign run_o    = ctrl_q[CTRL_RUN];
  assign inv_o    = ctrl_q[CTRL_INV];
  assign slow_o   = ctrl_q[CTRL_SLOW];
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             slow_sel_i,
  input  logic             slow_en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             step;
  logic [CNT_W-1:0] cnt_q;

  assign step   = run_i & (slow_sel_i ? slow_en_i : 1'b1);
  assign tick_o = step && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             inv_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] presc_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0] presc_sh_o,
  output logic [CNT_W-1:0] period_sh_o,
  output logic [CNT_W-1:0] duty_sh_o,
  output logic [CNT_W-1:0] pos_o,
  output logic             wrap_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] presc_sh_q, period_sh_q, duty_sh_q, pos_q;
  logic             out_q, wrap;

  assign wrap = tick_i && (pos_q == period_sh_q);

  // shadows follow live values while stopped, else only at a boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_sh_q  <= '0;
      period_sh_q <= '0;
      duty_sh_q   <= '0;
    end else if (!run_i || wrap) begin
      presc_sh_q  <= presc_i;
      period_sh_q <= period_i;
      duty_sh_q   <= duty_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (!run_i)  pos_q <= '0;
    else if (wrap)    pos_q <= '0;
    else if (tick_i)  pos_q <= pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_q <= 1'b0;
    else if (run_i)  out_q <= (pos_q <= duty_sh_q) ^ inv_i;
    else             out_q <= inv_i;
  end

  assign presc_sh_o  = presc_sh_q;
  assign period_sh_o = period_sh_q;
  assign duty_sh_o   = duty_sh_q;
  assign pos_o       = pos_q;
  assign wrap_o      = wrap;
  assign pwm_o       = out_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [CNT_W/8-1:0]   be_i,
  input  logic [CNT_W-1:0]     wdata_i,
  output logic [CNT_W-1:0]     rdata_o,
  input  logic                 slow_en_i,
  output logic                 pwm_o
);
  logic             run, inv, slow, tick, wrap;
  logic [CNT_W-1:0] presc_live, period_live, duty_live;
  logic [CNT_W-1:0] presc_sh, period_sh, duty_sh, prc, pos;

  pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .be_i     (be_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .presc_o  (presc_live),
    .period_o (period_live),
    .duty_o   (duty_live),
    .run_o    (run),
    .inv_o    (inv),
    .slow_o   (slow)
  );

  pwm_prescale #(.CNT_W(CNT_W)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .slow_sel_i (slow),
    .slow_en_i  (slow_en_i),
    .limit_i    (presc_sh),
    .tick_o     (tick),
    .cnt_o      (prc)
  );

  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .inv_i       (inv),
    .tick_i      (tick),
    .presc_i     (presc_live),
    .period_i    (period_live),
    .duty_i      (duty_live),
    .presc_sh_o  (presc_sh),
    .period_sh_o (period_sh),
    .duty_sh_o   (duty_sh),
    .pos_o       (pos),
    .wrap_o      (wrap),
    .pwm_o       (pwm_o)
  );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             inv,
  input logic             slow,
  input logic             slow_en_i,
  input logic [CNT_W-1:0] prc,
  input logic [CNT_W-1:0] pos,
  input logic [CNT_W-1:0] presc_sh,
  input logic [CNT_W-1:0] period_sh,
  input logic [CNT_W-1:0] duty_sh,
  input logic             wrap,
  input logic             pwm_o
);
  // R4
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> pwm_o == $past(inv));

  // R4
  idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (prc == '0 && pos == '0));

  // R10
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !wrap) |=> ($stable(presc_sh) && $stable(period_sh) && $stable(duty_sh)));

  // R7
  full_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && duty_sh >= period_sh) |=> pwm_o == !$past(inv));

  // R5
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> pos <= period_sh);

  // R6
  prc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> prc <= presc_sh);

  // R9
  slow_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && slow && !slow_en_i) |=> ($stable(prc) || !run));
endmodule

bind pwm_chan pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run       (run),
  .inv       (inv),
  .slow      (slow),
  .slow_en_i (slow_en_i),
  .prc       (prc),
  .pos       (pos),
  .presc_sh  (presc_sh),
  .period_sh (period_sh),
  .duty_sh   (duty_sh),
  .wrap      (wrap),
  .pwm_o     (pwm_o)
);

// File: tb/sim_pwm_chan.sv
`timescale 1ns/1ps
module sim_pwm_chan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [1:0]  be_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        slow_en_i = 1'b0;
  logic        pwm_o;

  int n_chk = 0;
  int n_fail = 0;
  int sc = 0;

  pwm_chan u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .be_i      (be_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .slow_en_i (slow_en_i),
    .pwm_o     (pwm_o)
  );

  always #4 clk_i = ~clk_i;

  initial begin
    forever begin
      @(negedge clk_i);
      sc++;
      slow_en_i = (sc % 4 == 0);
    end
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; be_i = be; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output int d);
    @(negedge clk_i);
    addr_i = a;
    #1;
    d = int'(rdata_o);
  endtask

  task automatic measure(input int cycles, output int hi, output int rises);
    logic prev;
    prev = pwm_o;
    hi = 0;
    rises = 0;
    repeat (cycles) begin
      @(negedge clk_i);
      if (pwm_o) hi++;
      if (pwm_o && !prev) rises++;
      prev = pwm_o;
    end
  endtask

  task automatic high_run(output int run);
    run = 0;
    while (pwm_o) begin
      run++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    int rd, hi, ri, run;
    repeat (3) @(negedge clk_i);
    check("R1", "pwm in reset", int'(pwm_o), 0);
    rst_ni = 1'b1;

    // R1 reset values
    for (int a = 0; a < 16; a += 2) begin
      bus_rd(4'(a), rd);
      check("R1", "reset readback", rd, 0);
    end
    check("R1", "pwm after reset", int'(pwm_o), 0);

    // R2 lanes and offsets
    bus_wr(4'h0, 16'hABCD, 2'b11); bus_rd(4'h0, rd); check("R2", "prescale word", rd, 16'hABCD);
    bus_wr(4'h0, 16'h1200, 2'b10); bus_rd(4'h0, rd); check("R2", "prescale high lane", rd, 16'h12CD);
    bus_wr(4'h2, 16'h5A5A, 2'b01); bus_rd(4'h2, rd); check("R2", "period low lane", rd, 16'h005A);
    bus_wr(4'h6, 16'hFFFF, 2'b11); bus_rd(4'h6, rd); check("R2", "duty word", rd, 16'hFFFF);
    bus_rd(4'h0, rd); check("R2", "prescale kept", rd, 16'h12CD);

    // R3 masks and holes
    bus_wr(4'h4, 16'hFF7E, 2'b11); bus_rd(4'h4, rd); check("R3", "control mask", rd, 16'h000E);
    bus_wr(4'h4, 16'hFFFF, 2'b10); bus_rd(4'h4, rd); check("R3", "control high lane ignored", rd, 16'h000E);
    bus_wr(4'hC, 16'hFFFF, 2'b11); bus_rd(4'hC, rd); check("R3", "extension mask", rd, 16'h00B0);
    bus_wr(4'h8, 16'hFFFF, 2'b11); bus_rd(4'h8, rd); check("R3", "hole 0x8", rd, 0);
    bus_wr(4'hA, 16'hFFFF, 2'b11); bus_rd(4'hA, rd); check("R3", "hole 0xA", rd, 0);
    bus_wr(4'hE, 16'hFFFF, 2'b11); bus_rd(4'hE, rd); check("R3", "hole 0xE", rd, 0);
    bus_rd(4'h6, rd); check("R3", "duty untouched by holes", rd, 16'hFFFF);
    check("R3", "pwm idle with mode bits", int'(pwm_o), 0);

    // R5 R6 R7 R8 sweep
    for (int inv = 0; inv < 2; inv++)
      for (int ps = 0; ps < 3; ps++)
        for (int pr = 0; pr < 5; pr++)
          for (int du = 0; du < 6; du++) begin
            int p_len, act, ehi;
            bus_wr(4'h4, 16'h0000, 2'b01);
            bus_wr(4'h0, 16'(ps), 2'b11);
            bus_wr(4'h2, 16'(pr), 2'b11);
            bus_wr(4'h6, 16'(du), 2'b11);
            bus_wr(4'h4, 16'h0080 | 16'(inv), 2'b01);
            p_len = (pr + 1) * (ps + 1);
            act = (((du < pr) ? du : pr) + 1) * (ps + 1);
            repeat (2 * p_len + 2) @(negedge clk_i);
            measure(2 * p_len, hi, ri);
            ehi = (inv != 0) ? 2 * (p_len - act) : 2 * act;
            if (du >= pr)        check("R7", "active cycles full duty", hi, ehi);
            else if (inv != 0)   check("R8", "inverted active cycles", hi, ehi);
            else                 check("R6", "active cycles", hi, ehi);
            check("R5", "rising edges per two periods", ri, (du < pr) ? 2 : 0);
          end

    // R9 slow tick source
    bus_wr(4'h4, 16'h0000, 2'b01);
    bus_wr(4'h0, 16'd1, 2'b11);
    bus_wr(4'h2, 16'd3, 2'b11);
    bus_wr(4'h6, 16'd1, 2'b11);
    bus_wr(4'h4, 16'h0082, 2'b01);
    repeat (70) @(negedge clk_i);
    measure(64, hi, ri);
    check("R9", "slow active cycles", hi, 32);
    check("R9", "slow rising edges", ri, 2);

    // R4 restart, R10 boundary update
    bus_wr(4'h4, 16'h0000, 2'b01);
    bus_wr(4'h0, 16'd0, 2'b11);
    bus_wr(4'h2, 16'd9, 2'b11);
    bus_wr(4'h6, 16'd2, 2'b11);
    bus_wr(4'h4, 16'h0080, 2'b01);
    @(negedge clk_i);
    check("R4", "active at restart", int'(pwm_o), 1);
    high_run(run);
    check("R4", "first pulse from zero", run, 3);
    while (!pwm_o) @(negedge clk_i);
    run = 1;
    addr_i = 4'h6; wdata_i = 16'd6; be_i = 2'b11; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    while (pwm_o) begin
      run++;
      @(negedge clk_i);
    end
    check("R10", "pulse in progress keeps old duty", run, 3);
    while (!pwm_o) @(negedge clk_i);
    high_run(run);
    check("R10", "next pulse uses new duty", run, 7);

    // R4 idle levels
    bus_wr(4'h4, 16'h0000, 2'b01);
    repeat (2) @(negedge clk_i);
    measure(10, hi, ri);
    check("R4", "stopped normal level", hi, 0);
    bus_wr(4'h4, 16'h0001, 2'b01);
    repeat (2) @(negedge clk_i);
    measure(10, hi, ri);
    check("R4", "stopped inverted level", hi, 10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule